// File: doc/BRIEF.md
# I2C bit-timing strobe generator

This block paces every bit on an I2C bus for a master sequencer. The sequencer asks for one of three bus events: a data bit, a START condition or a STOP condition. The block then decides when SCL is pulled low and when it is released. It also tells the sequencer when to put the next SDA value on the bus, when to sample SDA, when the SDA edge of a START or STOP belongs, and when the event is over. All of this timing is counted in ticks. A tick is the functional clock divided by a power of two.

A 32-bit timing word supplies four counts: SCL low time, SCL high time, START/STOP setup-and-hold, and data-valid delay. A second word of the same shape is used when high-speed mode is selected. The raw SCL and SDA inputs pass through a two-flop synchroniser and then a digital glitch filter, each with its own width. The high phase is only counted once the filtered SCL has really gone high, so a target that stretches the clock simply lengthens the bit. The filter delay adds to the bit period. All settings are captured when an event is accepted and stay fixed until it ends.

Cycle indices below count from the accepting clock edge: cycle k follows the k-th rising edge after it, so cycle 0 is the first cycle of the event. T stands for 2^P.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, busy, scl_low and every strobe are 0, and both filtered inputs read 1.
- R2: A tick occurs every 2^P functional clocks, where P = cfg_prescale (0 to 7). For a bit or STOP, scl_low is 1 from cycle 0 to cycle (LO+1)*T-1 and returns to 0 in cycle (LO+1)*T.
- R3: Timing word fields are: data-valid DV in bits 29:24, setup/hold SH in bits 23:16, high count HI in bits 13:8, low count LO in bits 5:0. All other bits are ignored.
- R4: For a bit or STOP, shift_stb pulses once, in cycle (DV+1)*T-1, which is the (DV+1)-th tick of the low phase. DV must not exceed LO.
- R5: After the low phase, SCL is released. The high phase starts the cycle after filtered SCL reads 1, having read 0 since the event began. With no stretching this is cycle H0 = (LO+1)*T+4+W, where W is the SCL filter width. The high phase lasts (HI+1)*T cycles. done pulses in its last cycle and busy is 0 in the next.
- R6: sample_stb pulses once, at the ((HI>>1)+1)-th tick of the high phase, that is cycle H0+((HI>>1)+1)*T-1.
- R7: op_code 1 (START) has no low phase and no shift_stb. It waits for filtered SCL high, so on an idle bus the setup phase starts in cycle 1. sda_fall_stb pulses in cycle (SH+1)*T and done pulses in cycle 2*(SH+1)*T.
- R8: op_code 2 (STOP) runs a low phase with shift_stb exactly as a bit does. It then waits for SCL high, starting setup at S0 = (LO+1)*T+4+W. sda_rise_stb pulses in cycle S0+(SH+1)*T-1 and done pulses in cycle S0+2*(SH+1)*T-1.
- R9: If hs_mode is 1 when an event is accepted, all counts come from cfg_timing_hs and cfg_timing_std is ignored.
- R10: Timing, prescale, filter widths and hs_mode are captured when an event is accepted. Changes made while busy do not affect the running event.
- R11: op_req is accepted only while busy is 0, and op_code 3 is never accepted. op_code 0 is a data bit. A rejected request leaves busy at 0 and produces no strobe.
- R12: The SCL filter width is cfg_filter[19:16] and the SDA filter width is cfg_filter[27:24]. A raw level held for at least W+1 clocks reaches the filtered output on the (W+3)-th rising edge after it was applied. Shorter pulses never reach it. W=0 leaves only the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | PSC_W | Tick divider exponent P |
| cfg_timing_std | input | 32 | Timing word for normal modes |
| cfg_timing_hs | input | 32 | Timing word for high-speed mode |
| cfg_filter | input | 32 | Glitch filter widths |
| hs_mode | input | 1 | Select the high-speed timing word |
| op_req | input | 1 | Request an event |
| op_code | input | 2 | 0 bit, 1 START, 2 STOP, 3 rejected |
| scl_in | input | 1 | Raw SCL from the pad |
| sda_in | input | 1 | Raw SDA from the pad |
| busy | output | 1 | An event is in progress |
| scl_low | output | 1 | Drive SCL low; 0 releases it |
| shift_stb | output | 1 | Place the next SDA value now |
| sample_stb | output | 1 | Sample SDA now |
| sda_fall_stb | output | 1 | Pull SDA low now (START) |
| sda_rise_stb | output | 1 | Release SDA now (STOP) |
| done | output | 1 | Last cycle of the event |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |

## Verification
The bench builds the block with its default parameters: a 3-bit prescale exponent and 4-bit filter widths. This puts the largest divider (P = 7, 128-clock ticks) and the widest filter (15) within reach, and one vector exercises each of them. Every counted field is also run at zero and at its full 6-bit value. The bench models SCL as a wired-AND line, which lets it stretch the clock and check that the high phase shifts by exactly the added delay. It also checks that mid-event changes to the timing words and requests made while busy leave the running event untouched.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int PSC_W = 3,
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_prescale,
  input  logic [31:0]      cfg_timing_std,
  input  logic [31:0]      cfg_timing_hs,
  input  logic [31:0]      cfg_filter,
  input  logic             hs_mode,
  input  logic             op_req,
  input  logic [1:0]       op_code,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             busy,
  output logic             scl_low,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             sda_fall_stb,
  output logic             sda_rise_stb,
  output logic             done,
  output logic             scl_filt,
  output logic             sda_filt
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam logic [1:0] OP_BIT = 2'd0, OP_START = 2'd1, OP_STOP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH, S_SU, S_HD} st_t;

  st_t              st;
  logic [1:0]       op;
  logic [7:0]       cnt, lim, sh;
  logic [5:0]       lo, hi, dv;
  logic [PSC_W-1:0] psc;
  logic [FLT_W-1:0] fw_c, fw_d;
  logic [DIV_W-1:0] pre, mask;
  logic             seen_low, tick, last;
  logic [1:0]       raw, flt;
  logic [31:0]      tw;
  logic             unused_bits;

  assign tw  = hs_mode ? cfg_timing_hs : cfg_timing_std;
  assign raw = {sda_in, scl_in};
  assign unused_bits = ^{tw[31:30], tw[15:14], tw[7:6], cfg_filter};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic q1, q2, qf;
    logic [FLT_W-1:0] fc, wid;
    assign wid = (g == 0) ? fw_c : fw_d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1 <= 1'b1; q2 <= 1'b1; qf <= 1'b1; fc <= '0;
      end else begin
        q1 <= raw[g];
        q2 <= q1;
        if (q2 == qf) fc <= '0;
        else if (fc >= wid) begin qf <= q2; fc <= '0; end
        else fc <= fc + 1'b1;
      end
    end
    assign flt[g] = qf;
  end
  assign scl_filt = flt[0];
  assign sda_filt = flt[1];

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psc));
    case (st)
      S_LOW:   lim = {2'b0, lo};
      S_HIGH:  lim = {2'b0, hi};
      default: lim = sh;
    endcase
  end

  assign tick = (st != S_IDLE) && (st != S_WAIT) && (pre == mask);
  assign last = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_BIT; cnt <= '0; pre <= '0; seen_low <= 1'b0;
      psc <= '0; lo <= '0; hi <= '0; sh <= '0; dv <= '0; fw_c <= '0; fw_d <= '0;
    end else begin
      pre <= (st == S_IDLE || st == S_WAIT || tick) ? '0 : pre + 1'b1;
      seen_low <= (st == S_IDLE) ? 1'b0 : (seen_low | ~scl_filt);
      case (st)
        S_IDLE: begin
          psc <= cfg_prescale;
          dv <= tw[29:24]; sh <= tw[23:16]; hi <= tw[13:8]; lo <= tw[5:0];
          fw_c <= cfg_filter[16 +: FLT_W];
          fw_d <= cfg_filter[24 +: FLT_W];
          cnt <= '0;
          if (op_req && op_code != 2'd3) begin
            op <= op_code;
            st <= (op_code == OP_START) ? S_WAIT : S_LOW;
          end
        end
        S_WAIT:
          if (scl_filt && (seen_low || op == OP_START)) begin
            st  <= (op == OP_BIT) ? S_HIGH : S_SU;
            cnt <= '0;
          end
        default:
          if (tick) begin
            if (last) begin
              cnt <= '0;
              case (st)
                S_LOW:   st <= S_WAIT;
                S_SU:    st <= S_HD;
                default: st <= S_IDLE;
              endcase
            end else cnt <= cnt + 1'b1;
          end
      endcase
    end
  end

  assign busy         = (st != S_IDLE);
  assign scl_low      = (st == S_LOW);
  assign shift_stb    = tick && (st == S_LOW) && (cnt == {2'b0, dv});
  assign sample_stb   = tick && (st == S_HIGH) && (cnt == {3'b0, hi[5:1]});
  assign sda_fall_stb = tick && last && (st == S_SU) && (op == OP_START);
  assign sda_rise_stb = tick && last && (st == S_SU) && (op == OP_STOP);
  assign done         = tick && last && (st == S_HIGH || st == S_HD);

  // R4: data changes only while SCL is held low
  p_shift_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> scl_low);

  // R6: sampling happens only with SCL released and seen high
  p_sample_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_filt && !scl_low));

  // R5: the event ends the cycle after done
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10: captured settings hold while busy
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lo) && $stable(hi) && $stable(sh) &&
                               $stable(dv) && $stable(psc)));

  // R11: a request while busy does not change the running event
  p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op));
endmodule

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  cfg_prescale = '0;
  logic [31:0] cfg_timing_std = '0, cfg_timing_hs = '0, cfg_filter = '0;
  logic hs_mode = 1'b0, op_req = 1'b0;
  logic [1:0] op_code = '0;
  logic stretch = 1'b0, sda_in = 1'b1, scl_in;
  logic busy, scl_low, shift_stb, sample_stb, sda_fall_stb, sda_rise_stb, done, scl_filt, sda_filt;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign scl_in = ~(scl_low | stretch);

  i2c_scl_timer i_i2c_scl_timer (
    .clk, .rst_n, .cfg_prescale, .cfg_timing_std, .cfg_timing_hs, .cfg_filter,
    .hs_mode, .op_req, .op_code, .scl_in, .sda_in, .busy, .scl_low, .shift_stb,
    .sample_stb, .sda_fall_stb, .sda_rise_stb, .done, .scl_filt, .sda_filt);

  typedef struct packed {
    logic [1:0] op; logic [2:0] p; logic [5:0] lo; logic [5:0] hi;
    logic [7:0] sh; logic [5:0] dv; logic [3:0] w; logic hs;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'd0, 3'd0, 6'd5,  6'd4,  8'd3,   6'd2,  4'd0,  1'b0},
    '{2'd0, 3'd1, 6'd3,  6'd5,  8'd2,   6'd1,  4'd2,  1'b0},
    '{2'd0, 3'd2, 6'd2,  6'd2,  8'd1,   6'd0,  4'd3,  1'b0},
    '{2'd1, 3'd0, 6'd3,  6'd3,  8'd4,   6'd1,  4'd0,  1'b0},
    '{2'd1, 3'd1, 6'd3,  6'd3,  8'd2,   6'd1,  4'd1,  1'b0},
    '{2'd2, 3'd0, 6'd4,  6'd3,  8'd3,   6'd1,  4'd1,  1'b0},
    '{2'd2, 3'd2, 6'd1,  6'd1,  8'd1,   6'd1,  4'd0,  1'b0},
    '{2'd0, 3'd0, 6'd7,  6'd6,  8'd2,   6'd3,  4'd0,  1'b1},
    '{2'd0, 3'd7, 6'd0,  6'd0,  8'd0,   6'd0,  4'd0,  1'b0},
    '{2'd0, 3'd0, 6'd63, 6'd63, 8'd9,   6'd63, 4'd15, 1'b0},
    '{2'd1, 3'd0, 6'd2,  6'd2,  8'd255, 6'd0,  4'd0,  1'b0}
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input vec_t v);
    return {2'b0, v.dv, v.sh, 2'b0, v.hi, 2'b0, v.lo};
  endfunction

  task automatic run(input vec_t v, input int stretch_k, input bit disturb);
    int t = 1 << v.p;
    int lowlen = (int'(v.lo) + 1) * t;
    int h0, x_shift = -1, x_sample = -1, x_fall = -1, x_rise = -1, x_done;
    int e_shift = -1, e_sample = -1, e_fall = -1, e_rise = -1, e_done = -1, e_rel = -1;
    int n_done = 0;
    logic low0 = 1'b0;
    string rq;
    cfg_prescale = v.p;
    hs_mode = v.hs;
    cfg_filter = {8'd0, 4'd0, v.w, 16'd0};
    if (v.hs) begin
      cfg_timing_hs = word(v);
      cfg_timing_std = {2'b0, 6'd9, 8'd40, 2'b0, 6'd33, 2'b0, 6'd50};
    end else begin
      cfg_timing_std = word(v);
      cfg_timing_hs = 32'hFFFF_FFFF;
    end
    repeat (20) @(negedge clk);
    op_code = v.op; op_req = 1'b1;
    if (stretch_k >= 0) stretch = 1'b1;
    @(negedge clk);
    op_req = 1'b0;
    h0 = ((stretch_k >= 0) ? stretch_k : lowlen) + 4 + int'(v.w);
    for (int k = 0; k < 3000; k++) begin
      if (k == 0) low0 = scl_low;
      if (shift_stb && e_shift < 0) e_shift = k;
      if (sample_stb && e_sample < 0) e_sample = k;
      if (sda_fall_stb && e_fall < 0) e_fall = k;
      if (sda_rise_stb && e_rise < 0) e_rise = k;
      if (!scl_low && low0 && e_rel < 0) e_rel = k;
      if (done) begin n_done++; if (e_done < 0) e_done = k; end
      if (k == stretch_k) stretch = 1'b0;
      if (disturb && k == 2) begin
        cfg_timing_std = {2'b0, 6'd1, 8'd1, 2'b0, 6'd1, 2'b0, 6'd1};
        cfg_prescale = 3'd3; hs_mode = 1'b1;
      end
      if (disturb && k == 3) begin op_req = 1'b1; op_code = 2'd1; end
      if (disturb && k == 4) op_req = 1'b0;
      if (e_done >= 0) break;
      @(negedge clk);
    end
    rq = v.hs ? "R9" : "R3";
    if (v.op == 2'd1) begin
      x_fall = (int'(v.sh) + 1) * t;
      x_done = 2 * (int'(v.sh) + 1) * t;
      check(e_shift, -1, "R7 no shift on START");
      check(e_fall, x_fall, "R7 sda_fall timing");
      check(e_done, x_done, "R7 done timing");
    end else begin
      x_shift = (int'(v.dv) + 1) * t - 1;
      check(int'(low0), 1, "R2 scl_low at cycle 0");
      check(e_rel, lowlen, "R2 low phase length");
      check(e_shift, x_shift, "R4 shift timing");
      if (v.op == 2'd0) begin
        x_sample = h0 + ((int'(v.hi) >> 1) + 1) * t - 1;
        x_done = h0 + (int'(v.hi) + 1) * t - 1;
        check(e_sample, x_sample, "R6 sample timing");
        check(e_done, x_done, "R5 done timing");
      end else begin
        x_rise = h0 + (int'(v.sh) + 1) * t - 1;
        x_done = h0 + 2 * (int'(v.sh) + 1) * t - 1;
        check(e_rise, x_rise, "R8 sda_rise timing");
        check(e_done, x_done, "R8 done timing");
      end
    end
    check(e_done, x_done, rq);
    check(n_done, 1, "R5 single done");
    if (disturb) check(e_fall, -1, "R11 START while busy ignored");
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check(int'(busy), 0, disturb ? "R11 no event after busy request" : "R5 busy cleared");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(busy), 0, "R1 busy");
    check(int'(scl_low), 0, "R1 scl_low");
    check(int'({shift_stb, sample_stb, sda_fall_stb, sda_rise_stb, done}), 0, "R1 strobes");
    check(int'({scl_filt, sda_filt}), 3, "R1 filters");

    foreach (VECS[i]) run(VECS[i], -1, 1'b0);
    run(VECS[0], 16, 1'b0);                 // R5 clock stretching
    run(VECS[0], -1, 1'b1);                 // R10 R11 disturbance mid-event

    // R11 op_code 3 rejected
    op_code = 2'd3; op_req = 1'b1;
    @(negedge clk);
    op_req = 1'b0;
    for (int j = 0; j < 5; j++) begin
      check(int'(busy | scl_low), 0, "R11 op_code 3 ignored");
      @(negedge clk);
    end

    // R12 SDA filter width 2: 2-cycle glitch rejected
    cfg_filter = {4'd0, 4'd2, 4'd0, 4'd0, 16'd0};
    repeat (4) @(negedge clk);
    first = -1; sda_in = 1'b0;
    for (int k = 1; k < 15; k++) begin
      @(negedge clk);
      if (!sda_filt && first < 0) first = k;
      if (k == 2) sda_in = 1'b1;
    end
    check(first, -1, "R12 SDA glitch rejected");
    // 3-cycle pulse passes at edge W+3
    first = -1; sda_in = 1'b0;
    for (int k = 1; k < 15; k++) begin
      @(negedge clk);
      if (!sda_filt && first < 0) first = k;
      if (k == 3) sda_in = 1'b1;
    end
    check(first, 5, "R12 SDA pulse latency");

    // R12 SCL filter width 0: single-cycle pulse passes at edge 3
    cfg_filter = 32'd0;
    repeat (10) @(negedge clk);
    first = -1; stretch = 1'b1;
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      if (!scl_filt && first < 0) first = k;
      if (k == 1) stretch = 1'b0;
    end
    check(first, 3, "R12 SCL unfiltered latency");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule